// File: doc/BRIEF.md
# Partition Power-Up Sequencer

This block brings one switchable power partition from an unknown state to running, one step at a time, in an order that keeps the partition safe. A single-cycle `start_i` pulse launches the sequence. Reset goes on first. Then the partition clock is gated off. Power is requested next, and the block waits for power-good. The clock is then ungated, and a fixed settle interval runs. After that the isolation clamps are asked to open, and the block waits for them to report released. Reset is lifted as the very last step. The power switch and the clamp cells sit outside the block; this block only drives their request lines and watches their status inputs.

Every wait is timed in microseconds. The microsecond base comes from a prescaler that counts `CYC_PER_US` clock cycles. A poll-type wait gives up after `POLL_LIMIT` microseconds. A power-good wait that runs out is treated as a warning and the sequence goes on. If `PWR_FAIL_HARD` is set, it is treated as a failure instead. A clamp wait that runs out is always a failure. A failure unwinds the partition to a safe state. If the clock had already been ungated, it is gated first. Power is then dropped with reset held, and an error pulse ends the attempt.

States, all named here: `ST_IDLE`, `ST_RST_ON`, `ST_CLK_OFF`, `ST_PWR_WAIT`, `ST_SETTLE`, `ST_CLAMP_WAIT`, `ST_FAIL_CLK`, `ST_FAIL_OFF`.

Transitions:
- idle to rst_on, on start.
- rst_on to clk_off.
- clk_off to settle when power-good is already high, otherwise clk_off to pwr_wait.
- pwr_wait to settle, on power-good or on a soft timeout.
- pwr_wait to fail_off, on a hard timeout.
- settle to clamp_wait, after the settle time.
- clamp_wait to idle, on clamp release (success).
- clamp_wait to fail_clk, on timeout.
- fail_clk to fail_off.
- fail_off to idle (error).

Top module: `pwr_part_seq`

## Requirements
- R1: While reset is applied and after it: `part_rst_o`=1, `clk_en_o`=0, `pwr_req_o`=0, `unclamp_req_o`=0, and `done_o`, `err_o` and `warn_o` are all 0.
- R2: Sample the outputs one cycle after a start pulse is accepted: `part_rst_o` is 1. One cycle later, `clk_en_o` is 0. One cycle after that, `pwr_req_o` is 1 unless power-good was already high.
- R3: `clk_en_o` stays 0 while `pwr_req_o` is 1 and power-good has not been seen. It goes to 1 within two cycles after power-good rises.
- R4: `unclamp_req_o` rises exactly `SETTLE_US`*`CYC_PER_US` cycles after `clk_en_o` rises.
- R5: When the clamps report released, the block does all of the following in the same cycle: drops `part_rst_o`, drops `unclamp_req_o` and pulses `done_o`. It leaves `clk_en_o` and `pwr_req_o` at 1. Reset is the last output to change.
- R6: If power-good stays low for `POLL_LIMIT` microseconds, the soft variant does two things in the same cycle: it pulses `warn_o` and sets `clk_en_o` to 1. This happens exactly `POLL_LIMIT`*`CYC_PER_US` cycles after `pwr_req_o` rose. The sequence then goes on.
- R7: If the clamps do not release within `POLL_LIMIT` microseconds, the block unwinds in three steps. First, exactly `POLL_LIMIT`*`CYC_PER_US` cycles after `unclamp_req_o` rose, `clk_en_o` and `unclamp_req_o` fall. One cycle later, `pwr_req_o` falls. One cycle after that, `err_o` pulses. `part_rst_o` stays 1 throughout.
- R8: In the hard variant (`PWR_FAIL_HARD`=1), a power-good timeout makes `pwr_req_o` fall exactly `POLL_LIMIT`*`CYC_PER_US` cycles after it rose. `err_o` pulses one cycle later. `clk_en_o` stays 0 and `warn_o` never pulses.
- R9: If power-good is already high when the clock has been stopped, `clk_en_o` returns to 1 on the next cycle. `pwr_req_o` never falls during that run, and `warn_o` stays 0.
- R10: A start pulse that arrives while a sequence is running has no effect. After `done_o`, `part_rst_o` stays 0.
- R11: `done_o` and `err_o` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; honoured only when idle |
| pwr_good_i | input | 1 | Partition reports its supply is up |
| clamp_rel_i | input | 1 | Isolation clamps report open |
| part_rst_o | output | 1 | Partition reset, 1 = held in reset |
| clk_en_o | output | 1 | Partition clock enable |
| pwr_req_o | output | 1 | Request to the power switch, 1 = on |
| unclamp_req_o | output | 1 | Request to open the isolation clamps |
| done_o | output | 1 | One-cycle pulse: sequence finished |
| err_o | output | 1 | One-cycle pulse: sequence failed and unwound |
| warn_o | output | 1 | One-cycle pulse: power-good wait timed out, sequence continued |

## Verification
The status inputs are driven in several patterns, each meant to separate a different path through the machine:
- **Power-good arriving late.** This shows that the clock waits for power.
- **Power-good already high.** This takes the skip path and shows that no power request toggles.
- **Power-good never arriving.** The soft and hard variants are tried side by side. This separates the warn-and-continue behaviour from the early unwind that leaves the clock alone.
- **Clamps that never release.** This drives the unwind that gates the clock first.

A start pulse given mid-run shows that busy starts are ignored. Each timeout and the settle interval are measured in whole cycles against `CYC_PER_US` times the microsecond limit.

// File: rtl/pwr_part_seq_pkg.sv
package pwr_part_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RST_ON     = 3'd1,
        ST_CLK_OFF    = 3'd2,
        ST_PWR_WAIT   = 3'd3,
        ST_SETTLE     = 3'd4,
        ST_CLAMP_WAIT = 3'd5,
        ST_FAIL_CLK   = 3'd6,
        ST_FAIL_OFF   = 3'd7
    } seq_state_e;

endpackage

// File: rtl/pps_us_timer.sv
// Microsecond timer: prescaler plus saturating microsecond count, cleared on every state change.
module pps_us_timer #(
    parameter int CYC_PER_US = 100,
    parameter int US_W       = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    output logic            tick_o,
    output logic [US_W-1:0] us_o
);
    localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [PW-1:0]   PRE_LAST = PW'(CYC_PER_US - 1);
    localparam logic [US_W-1:0] US_MAX   = '1;

    logic [PW-1:0] pre_q;

    assign tick_o = (pre_q == PRE_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            us_o  <= '0;
        end else if (clr_i) begin
            pre_q <= '0;
            us_o  <= '0;
        end else if (tick_o) begin
            pre_q <= '0;
            if (us_o != US_MAX) us_o <= us_o + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R4: prescaler never leaves its range, so each microsecond is CYC_PER_US cycles
    p_pre_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pre_q) < CYC_PER_US);

endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
    import pwr_part_seq_pkg::*;
#(
    parameter int POLL_LIMIT    = 100,
    parameter int SETTLE_US     = 20,
    parameter int US_W          = 7,
    parameter bit PWR_FAIL_HARD = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            pwr_good_i,
    input  logic            clamp_rel_i,
    input  logic            tick_i,
    input  logic [US_W-1:0] us_i,
    output logic            timer_clr_o,
    output logic            part_rst_o,
    output logic            clk_en_o,
    output logic            pwr_req_o,
    output logic            unclamp_req_o,
    output logic            done_o,
    output logic            err_o,
    output logic            warn_o
);
    localparam logic [US_W-1:0] POLL_LAST   = US_W'(POLL_LIMIT - 1);
    localparam logic [US_W-1:0] SETTLE_LAST = US_W'(SETTLE_US - 1);

    seq_state_e state_q, state_d;
    seq_state_e pwr_to_next;
    logic       pwr_to_warn;
    logic       pwr_to;

    generate
        if (PWR_FAIL_HARD) begin : g_pwr_hard
            assign pwr_to_next = ST_FAIL_OFF;
            assign pwr_to_warn = 1'b0;
        end else begin : g_pwr_soft
            assign pwr_to_next = ST_SETTLE;
            assign pwr_to_warn = 1'b1;
        end
    endgenerate

    // next-state logic
    always_comb begin
        state_d = state_q;
        pwr_to  = 1'b0;
        unique case (state_q)
            ST_IDLE:       if (start_i) state_d = ST_RST_ON;
            ST_RST_ON:     state_d = ST_CLK_OFF;
            ST_CLK_OFF:    state_d = pwr_good_i ? ST_SETTLE : ST_PWR_WAIT;
            ST_PWR_WAIT: begin
                if (pwr_good_i) begin
                    state_d = ST_SETTLE;
                end else if (tick_i && us_i == POLL_LAST) begin
                    pwr_to  = 1'b1;
                    state_d = pwr_to_next;
                end
            end
            ST_SETTLE:     if (tick_i && us_i == SETTLE_LAST) state_d = ST_CLAMP_WAIT;
            ST_CLAMP_WAIT: begin
                if (clamp_rel_i)                            state_d = ST_IDLE;
                else if (tick_i && us_i == POLL_LAST)       state_d = ST_FAIL_CLK;
            end
            ST_FAIL_CLK:   state_d = ST_FAIL_OFF;
            ST_FAIL_OFF:   state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    assign timer_clr_o = (state_d != state_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs, updated on the edge that enters a state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_rst_o    <= 1'b1;
            clk_en_o      <= 1'b0;
            pwr_req_o     <= 1'b0;
            unclamp_req_o <= 1'b0;
            done_o        <= 1'b0;
            err_o         <= 1'b0;
            warn_o        <= 1'b0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            warn_o <= pwr_to && pwr_to_warn;
            if (state_d != state_q) begin
                unique case (state_d)
                    ST_RST_ON:     part_rst_o <= 1'b1;
                    ST_CLK_OFF:    clk_en_o   <= 1'b0;
                    ST_PWR_WAIT:   pwr_req_o  <= 1'b1;
                    ST_SETTLE: begin
                        pwr_req_o <= 1'b1;
                        clk_en_o  <= 1'b1;
                    end
                    ST_CLAMP_WAIT: unclamp_req_o <= 1'b1;
                    ST_FAIL_CLK: begin
                        clk_en_o      <= 1'b0;
                        unclamp_req_o <= 1'b0;
                    end
                    ST_FAIL_OFF: begin
                        part_rst_o    <= 1'b1;
                        pwr_req_o     <= 1'b0;
                        unclamp_req_o <= 1'b0;
                    end
                    ST_IDLE: begin
                        if (state_q == ST_CLAMP_WAIT) begin
                            part_rst_o    <= 1'b0;
                            unclamp_req_o <= 1'b0;
                            done_o        <= 1'b1;
                        end else begin
                            err_o <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: power is requested only with reset held and the clock stopped
    p_pwr_after_clk_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_req_o) |-> (part_rst_o && !clk_en_o));

    // R3: the clock comes back only while power is requested
    p_clk_after_pwr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en_o) |-> pwr_req_o);

    // R5: clamps open only with clock and power on
    p_unclamp_needs_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        unclamp_req_o |-> (clk_en_o && pwr_req_o));

    // R5: reset release is the final step of a good run
    p_rst_release_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(part_rst_o) |-> (done_o && clk_en_o && pwr_req_o && $past(unclamp_req_o)));

    // R7: the unwind holds reset with the clock stopped
    p_fail_safe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAIL_OFF) |-> (part_rst_o && !clk_en_o));

    // R8: power is never dropped with the clock running
    p_pwr_off_clk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_req_o) |-> !clk_en_o);

    // R10: no restart from a busy state
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_RST_ON));

    // R11: single-cycle, mutually exclusive completion pulses
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);
    p_done_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

endmodule

// File: rtl/pwr_part_seq.sv
module pwr_part_seq #(
    parameter int CYC_PER_US    = 100,
    parameter int POLL_LIMIT    = 100,
    parameter int SETTLE_US     = 20,
    parameter bit PWR_FAIL_HARD = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic pwr_good_i,
    input  logic clamp_rel_i,
    output logic part_rst_o,
    output logic clk_en_o,
    output logic pwr_req_o,
    output logic unclamp_req_o,
    output logic done_o,
    output logic err_o,
    output logic warn_o
);
    localparam int US_SPAN = (POLL_LIMIT > SETTLE_US) ? POLL_LIMIT : SETTLE_US;
    localparam int US_W    = $clog2(US_SPAN + 1);

    logic            tick;
    logic            timer_clr;
    logic [US_W-1:0] us_cnt;

    pps_us_timer #(
        .CYC_PER_US (CYC_PER_US),
        .US_W       (US_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (timer_clr),
        .tick_o (tick),
        .us_o   (us_cnt)
    );

    pps_fsm #(
        .POLL_LIMIT    (POLL_LIMIT),
        .SETTLE_US     (SETTLE_US),
        .US_W          (US_W),
        .PWR_FAIL_HARD (PWR_FAIL_HARD)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .pwr_good_i    (pwr_good_i),
        .clamp_rel_i   (clamp_rel_i),
        .tick_i        (tick),
        .us_i          (us_cnt),
        .timer_clr_o   (timer_clr),
        .part_rst_o    (part_rst_o),
        .clk_en_o      (clk_en_o),
        .pwr_req_o     (pwr_req_o),
        .unclamp_req_o (unclamp_req_o),
        .done_o        (done_o),
        .err_o         (err_o),
        .warn_o        (warn_o)
    );

endmodule

// File: tb/pwr_part_seq_test.sv
module pwr_part_seq_test;
    localparam int CPU  = 4;
    localparam int POLL = 100;
    localparam int SETL = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, start_h = 1'b0;
    logic pg = 1'b0, crel = 1'b0;
    logic rst_o, clk_o, pwr_o, ucl_o, done_o, err_o, warn_o;
    logic rst_h, clk_h, pwr_h, ucl_h, done_h, err_h, warn_h;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pwr_part_seq #(.CYC_PER_US(CPU), .POLL_LIMIT(POLL), .SETTLE_US(SETL), .PWR_FAIL_HARD(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .pwr_good_i(pg), .clamp_rel_i(crel),
        .part_rst_o(rst_o), .clk_en_o(clk_o), .pwr_req_o(pwr_o), .unclamp_req_o(ucl_o),
        .done_o(done_o), .err_o(err_o), .warn_o(warn_o));

    pwr_part_seq #(.CYC_PER_US(CPU), .POLL_LIMIT(POLL), .SETTLE_US(SETL), .PWR_FAIL_HARD(1'b1)) uut_hard (
        .clk(clk), .rst_n(rst_n), .start_i(start_h), .pwr_good_i(pg), .clamp_rel_i(crel),
        .part_rst_o(rst_h), .clk_en_o(clk_h), .pwr_req_o(pwr_h), .unclamp_req_o(ucl_h),
        .done_o(done_h), .err_o(err_h), .warn_o(warn_h));

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // R1
    task automatic t_reset();
        chk("R1 rst", rst_o, 1); chk("R1 clk", clk_o, 0); chk("R1 pwr", pwr_o, 0);
        chk("R1 ucl", ucl_o, 0);
        chk("R1 pulses", int'(done_o) + int'(err_o) + int'(warn_o), 0);
    endtask

    // late power-good, normal completion: R2 R3 R4 R5 R11
    task automatic t_normal();
        int n;
        pulse_start();                       // sample 1
        chk("R2 rst on", rst_o, 1);
        @(negedge clk); chk("R2 clk off", clk_o, 0); chk("R2 pwr not yet", pwr_o, 0);
        @(negedge clk); chk("R2 pwr req", pwr_o, 1);
        repeat (30) @(negedge clk);
        chk("R3 clk held off", clk_o, 0);
        pg = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3 clk on after pg", clk_o, 1);
        n = 0;
        while (!ucl_o && n < 5000) begin @(negedge clk); n++; end
        chk("R4 settle cycles", n + 1, SETL * CPU);
        repeat (5) @(negedge clk);
        chk("R5 rst held while unclamping", rst_o, 1);
        crel = 1'b1;
        n = 0;
        while (!done_o && n < 50) begin @(negedge clk); n++; end
        chk("R5 done", done_o, 1); chk("R5 rst released", rst_o, 0);
        chk("R5 ucl dropped", ucl_o, 0); chk("R5 clk kept", clk_o, 1); chk("R5 pwr kept", pwr_o, 1);
        crel = 1'b0;
        @(negedge clk);
        chk("R11 done single", done_o, 0);
    endtask

    // already powered + busy start: R2 R9 R10
    task automatic t_powered();
        int n; bit pwr_fell; bit warned;
        pulse_start();
        chk("R2 rst rises", rst_o, 1); chk("R2 clk still on", clk_o, 1);
        @(negedge clk); chk("R2 clk off", clk_o, 0);
        @(negedge clk); chk("R9 clk back next cycle", clk_o, 1);
        repeat (10) @(negedge clk);
        pulse_start();                        // busy start, R10
        n = 0; pwr_fell = 1'b0; warned = 1'b0;
        while (!ucl_o && n < 5000) begin
            @(negedge clk); n++;
            if (!pwr_o) pwr_fell = 1'b1;
            if (warn_o) warned = 1'b1;
        end
        crel = 1'b1;
        n = 0;
        while (!done_o && n < 50) begin @(negedge clk); n++; end
        chk("R9 no pwr toggle", int'(pwr_fell), 0);
        chk("R9 no warn", int'(warned), 0);
        chk("R10 done", done_o, 1);
        crel = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 no restart", rst_o, 0);
    endtask

    // clamps never release: R7 R11
    task automatic t_clamp_fail();
        int n;
        pulse_start();
        n = 0;
        while (!ucl_o && n < 5000) begin @(negedge clk); n++; end
        n = 0;
        while (clk_o && n < 5000) begin @(negedge clk); n++; end
        chk("R7 clamp timeout cycles", n, POLL * CPU);
        chk("R7 ucl dropped", ucl_o, 0); chk("R7 pwr still on", pwr_o, 1);
        @(negedge clk); chk("R7 pwr off", pwr_o, 0); chk("R7 rst held", rst_o, 1);
        chk("R7 no err yet", err_o, 0);
        @(negedge clk); chk("R7 err", err_o, 1); chk("R11 no done with err", done_o, 0);
        @(negedge clk); chk("R11 err single", err_o, 0);
        pg = 1'b0;
    endtask

    // soft power-good timeout: R6
    task automatic t_pwr_soft();
        int n;
        pulse_start();
        n = 0;
        while (!pwr_o && n < 50) begin @(negedge clk); n++; end
        n = 0;
        while (!clk_o && n < 5000) begin @(negedge clk); n++; end
        chk("R6 pg timeout cycles", n, POLL * CPU);
        chk("R6 warn", warn_o, 1);
        @(negedge clk); chk("R6 warn single", warn_o, 0);
        n = 0;
        while (!ucl_o && n < 5000) begin @(negedge clk); n++; end
        crel = 1'b1;
        n = 0;
        while (!done_o && n < 50) begin @(negedge clk); n++; end
        chk("R6 continues to done", done_o, 1);
        crel = 1'b0;
    endtask

    // hard power-good timeout: R8
    task automatic t_pwr_hard();
        int n; bit clk_seen; bit warned;
        @(negedge clk); start_h = 1'b1;
        @(negedge clk); start_h = 1'b0;
        n = 0;
        while (!pwr_h && n < 50) begin @(negedge clk); n++; end
        n = 0; clk_seen = 1'b0; warned = 1'b0;
        while (pwr_h && n < 5000) begin
            @(negedge clk); n++;
            if (clk_h) clk_seen = 1'b1;
            if (warn_h) warned = 1'b1;
        end
        chk("R8 pwr drop cycles", n, POLL * CPU);
        chk("R8 clk untouched", int'(clk_seen), 0);
        chk("R8 rst held", rst_h, 1);
        @(negedge clk); chk("R8 err", err_h, 1);
        chk("R8 no warn", int'(warned) + int'(warn_h), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_normal();
        t_powered();
        t_clamp_fail();
        t_pwr_soft();
        t_pwr_hard();
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule